// File: doc/BRIEF.md
# Hashed Address Signature Unit

This unit keeps a small bank of wide address signatures and carries out the set operations that speculative-execution and coherence logic performs on them. An address is hashed into signature form. The line-offset bits are dropped and the tag bits are scrambled by a fixed permutation. The result is cut into a few fields, and each field is one-hot decoded into its own slice of the signature. Accumulating many addresses into one register gives a compact, conservative record of a set of addresses.

Each cycle the owner can issue one write-type operation on the bank: clear a register, accumulate an address into it, or store the AND or the OR of two registers into it. Three queries are combinational and always live. The first reports whether the register on port A is empty. The second reports whether the intersection of the registers on ports A and B is empty. The third reports whether the address on the address port is a conservative member of register A. A decode operation turns register A into a mask of the cache sets that could hold one of its addresses. The mask is registered and marked by a one-cycle strobe. The walk over those sets is done by a separate unit.

Top module: `addr_sig_unit`

## Requirements
- R1: After reset every register in the bank is all zeros, so `sig_out` is zero and `sig_empty` is 1 for every selection, and `set_mask_valid` is 0.
- R2: Encoding of an address: the line address is `addr[31:6]`, the set index is `addr[11:6]`, and the tag is `addr[31:12]` (tag bit i is `addr[12+i]`). Permuted bit q[j] equals tag bit (7*j mod 20). Field 0 is {q[1], q[0], set index}. Field k (k = 1..3) has bit b equal to q[(8k-6+b) mod 20]. The signature sets bit 256*k + (value of field k) for each k. An accumulate operation (`op_code` 2) ORs this encoding into the `dst_sel` register at the clock edge.
- R3: A clear operation (`op_code` 1) sets the `dst_sel` register to all zeros at the clock edge.
- R4: An AND operation (`op_code` 3) writes the bitwise AND of registers `src_a_sel` and `src_b_sel` into register `dst_sel` at the clock edge.
- R5: An OR operation (`op_code` 4) writes the bitwise OR of registers `src_a_sel` and `src_b_sel` into register `dst_sel` at the clock edge.
- R6: `sig_empty` is 1 exactly when at least one of the four 256-bit fields of register `src_a_sel` is all zeros, even when other fields hold ones.
- R7: `isect_empty` is 1 exactly when the AND of registers `src_a_sel` and `src_b_sel` has at least one all-zero field.
- R8: `addr_member` is 1 exactly when the encoding of `addr` ANDed with register `src_a_sel` has no all-zero field, so an address accumulated into a register always tests as a member of it.
- R9: A decode operation (`op_code` 5) loads `set_mask` on the clock edge and raises `set_mask_valid` for that one cycle only. Bit s of the mask is 1 when any of bits s, s+64, s+128 or s+192 of register `src_a_sel` is set, or when any of fields 1 to 3 of that register is all zeros.
- R10: When `op_valid` is 0, or the operation is NOP (`op_code` 0) or decode, no register changes. A write-type operation changes only the `dst_sel` register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies `op_code` for this cycle |
| op_code | input | 3 | 0 NOP, 1 clear, 2 accumulate, 3 AND, 4 OR, 5 decode |
| dst_sel | input | 2 | Register written by clear, accumulate, AND and OR |
| src_a_sel | input | 2 | First operand; also the register that the queries and decode read |
| src_b_sel | input | 2 | Second operand for AND, OR and the intersection query |
| addr | input | 32 | Byte address for accumulate and for the membership query |
| sig_out | output | 1024 | Contents of register `src_a_sel` |
| sig_empty | output | 1 | Register `src_a_sel` has an all-zero field |
| isect_empty | output | 1 | AND of registers A and B has an all-zero field |
| addr_member | output | 1 | `addr` is a conservative member of register A |
| set_mask | output | 64 | Candidate cache-set mask from the last decode |
| set_mask_valid | output | 1 | One-cycle strobe marking a fresh `set_mask` |

## Verification
A bad hash bit or a write to the wrong register shows on `sig_out` and on the membership query in the cycle right after the edge that wrote it. The bench compares the full register against its own model after every operation. A one-field emptiness detector that wrongly checks the whole vector only fails on signatures that are partly filled, so a directed case builds one through an AND of two addresses that differ only in their set index. Decode errors appear one edge after the decode command, both as a wrong mask and as a strobe that is missing or held too long.

// File: rtl/addr_sig_pkg.sv
package addr_sig_pkg;

  typedef enum logic [2:0] {
    SIG_NOP    = 3'd0,
    SIG_CLEAR  = 3'd1,
    SIG_ACCUM  = 3'd2,
    SIG_AND    = 3'd3,
    SIG_OR     = 3'd4,
    SIG_DECODE = 3'd5
  } sig_op_e;

  // total signature width: one one-hot slice per field
  function automatic int sig_width(input int num_fields, input int field_w);
    return num_fields * (1 << field_w);
  endfunction

  // source tag bit feeding permuted position j
  function automatic int perm_src(input int j, input int mult, input int n);
    return (j * mult) % n;
  endfunction

  // position in the permuted pool feeding field k, bit b (non-set bits)
  function automatic int pool_index(input int k, input int b, input int field_w,
                                    input int set_w, input int n);
    int idx;
    if (k == 0) idx = b - set_w;
    else        idx = (field_w - set_w) + (k - 1) * field_w + b;
    return idx % n;
  endfunction

endpackage

// File: rtl/sig_hash_encoder.sv
module sig_hash_encoder
  import addr_sig_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 6,
  parameter int SET_W      = 6,
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 4,
  parameter int PERM_MULT  = 7,
  localparam int SIG_W     = sig_width(NUM_FIELDS, FIELD_W),
  localparam int LINE_W    = ADDR_W - OFS_W
) (
  input  logic [LINE_W-1:0] line_addr,
  output logic [SIG_W-1:0]  sig_vec
);
  localparam int TAG_W = LINE_W - SET_W;
  localparam int FSZ   = 1 << FIELD_W;

  logic [TAG_W-1:0] tag;
  logic [TAG_W-1:0] perm_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_val;

  assign tag = line_addr[LINE_W-1:SET_W];

  // fixed permutation of the tag bits
  for (genvar j = 0; j < TAG_W; j++) begin : g_perm
    assign perm_q[j] = tag[perm_src(j, PERM_MULT, TAG_W)];
  end

  // field 0 carries the set index in its low bits; the rest come from the pool
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
      if (k == 0 && b < SET_W) begin : g_set
        assign field_val[k][b] = line_addr[b];
      end else begin : g_pool
        assign field_val[k][b] = perm_q[pool_index(k, b, FIELD_W, SET_W, TAG_W)];
      end
    end
    // one-hot decode of the field into its slice
    for (genvar v = 0; v < FSZ; v++) begin : g_hot
      assign sig_vec[k*FSZ + v] = (field_val[k] == FIELD_W'(v));
    end
  end

endmodule

// File: rtl/sig_null_check.sv
module sig_null_check
  import addr_sig_pkg::*;
#(
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 4,
  localparam int SIG_W     = sig_width(NUM_FIELDS, FIELD_W)
) (
  input  logic [SIG_W-1:0]      sig,
  output logic [NUM_FIELDS-1:0] field_zero,
  output logic                  is_null
);
  localparam int FSZ = 1 << FIELD_W;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fz
    assign field_zero[k] = ~|sig[k*FSZ +: FSZ];
  end

  // a single all-zero field makes the whole set empty
  assign is_null = |field_zero;

endmodule

// File: rtl/sig_set_decoder.sv
module sig_set_decoder
  import addr_sig_pkg::*;
#(
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 4,
  parameter int SET_W      = 6,
  localparam int SIG_W     = sig_width(NUM_FIELDS, FIELD_W),
  localparam int NUM_SETS  = 1 << SET_W
) (
  input  logic [SIG_W-1:0]    sig,
  output logic [NUM_SETS-1:0] set_mask
);
  localparam int FSZ   = 1 << FIELD_W;
  localparam int ALIAS = 1 << (FIELD_W - SET_W);

  logic [NUM_FIELDS-1:0] upper_zero;
  logic                  any_upper_zero;

  assign upper_zero[0] = 1'b0;
  for (genvar k = 1; k < NUM_FIELDS; k++) begin : g_uz
    assign upper_zero[k] = ~|sig[k*FSZ +: FSZ];
  end
  assign any_upper_zero = |upper_zero;

  // field 0 values sharing the same low set bits alias to one set
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [ALIAS-1:0] hits;
    for (genvar t = 0; t < ALIAS; t++) begin : g_alias
      assign hits[t] = sig[t*NUM_SETS + s];
    end
    assign set_mask[s] = (|hits) | any_upper_zero;
  end

endmodule

// File: rtl/addr_sig_unit.sv
module addr_sig_unit
  import addr_sig_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 6,
  parameter int SET_W      = 6,
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 4,
  parameter int NUM_REGS   = 4,
  parameter int PERM_MULT  = 7,
  localparam int SIG_W     = sig_width(NUM_FIELDS, FIELD_W),
  localparam int SEL_W     = $clog2(NUM_REGS),
  localparam int NUM_SETS  = 1 << SET_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [2:0]          op_code,
  input  logic [SEL_W-1:0]    dst_sel,
  input  logic [SEL_W-1:0]    src_a_sel,
  input  logic [SEL_W-1:0]    src_b_sel,
  input  logic [ADDR_W-1:0]   addr,
  output logic [SIG_W-1:0]    sig_out,
  output logic                sig_empty,
  output logic                isect_empty,
  output logic                addr_member,
  output logic [NUM_SETS-1:0] set_mask,
  output logic                set_mask_valid
);
  logic [NUM_REGS-1:0][SIG_W-1:0] bank;
  logic [SIG_W-1:0] reg_a, reg_b, enc_sig, and_ab, or_ab, probe_vec;
  logic [NUM_SETS-1:0] decoded_mask;
  logic member_null;
  logic [NUM_FIELDS-1:0] unused_fz_a, unused_fz_ab, unused_fz_m;
  logic unused_offset;

  // named events for the checks
  logic clr_fire, acc_fire, and_fire, or_fire, dec_fire, wr_fire;

  assign clr_fire = op_valid && (op_code == SIG_CLEAR);
  assign acc_fire = op_valid && (op_code == SIG_ACCUM);
  assign and_fire = op_valid && (op_code == SIG_AND);
  assign or_fire  = op_valid && (op_code == SIG_OR);
  assign dec_fire = op_valid && (op_code == SIG_DECODE);
  assign wr_fire  = clr_fire | acc_fire | and_fire | or_fire;

  assign unused_offset = ^addr[OFS_W-1:0];

  assign reg_a     = bank[src_a_sel];
  assign reg_b     = bank[src_b_sel];
  assign and_ab    = reg_a & reg_b;
  assign or_ab     = reg_a | reg_b;
  assign probe_vec = enc_sig & reg_a;
  assign sig_out   = reg_a;

  sig_hash_encoder #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SET_W(SET_W), .FIELD_W(FIELD_W),
    .NUM_FIELDS(NUM_FIELDS), .PERM_MULT(PERM_MULT)
  ) u_enc (
    .line_addr(addr[ADDR_W-1:OFS_W]),
    .sig_vec  (enc_sig)
  );

  sig_null_check #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_null_a (
    .sig(reg_a), .field_zero(unused_fz_a), .is_null(sig_empty)
  );

  sig_null_check #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_null_ab (
    .sig(and_ab), .field_zero(unused_fz_ab), .is_null(isect_empty)
  );

  sig_null_check #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_null_mem (
    .sig(probe_vec), .field_zero(unused_fz_m), .is_null(member_null)
  );

  assign addr_member = ~member_null;

  sig_set_decoder #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .SET_W(SET_W)) u_dec (
    .sig(reg_a), .set_mask(decoded_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank           <= '0;
      set_mask       <= '0;
      set_mask_valid <= 1'b0;
    end else begin
      set_mask_valid <= dec_fire;
      if (dec_fire) set_mask <= decoded_mask;
      if (clr_fire)      bank[dst_sel] <= '0;
      else if (acc_fire) bank[dst_sel] <= bank[dst_sel] | enc_sig;
      else if (and_fire) bank[dst_sel] <= and_ab;
      else if (or_fire)  bank[dst_sel] <= or_ab;
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(bank));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (bank[$past(dst_sel)] == '0));

  // R2
  accum_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> ((bank[$past(dst_sel)] & $past(enc_sig)) == $past(enc_sig)));

  // R9
  decode_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> set_mask_valid);

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_fire |=> !set_mask_valid);

  // R6
  zero_sig_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_out == '0) |-> sig_empty);

  // R8
  member_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_member |-> !sig_empty);

  // R7
  isect_of_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_empty |-> isect_empty);

endmodule

// File: tb/addr_sig_unit_tb.sv
module addr_sig_unit_tb;
  localparam int SW = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [1:0] dst_sel = '0, src_a_sel = '0, src_b_sel = '0;
  logic [31:0] addr = '0;
  logic [SW-1:0] sig_out;
  logic sig_empty, isect_empty, addr_member, set_mask_valid;
  logic [63:0] set_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [SW-1:0] model [4];

  always #5 clk = ~clk;

  addr_sig_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_sel(dst_sel), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .addr(addr),
    .sig_out(sig_out), .sig_empty(sig_empty), .isect_empty(isect_empty),
    .addr_member(addr_member), .set_mask(set_mask), .set_mask_valid(set_mask_valid)
  );

  // bench encoding: scatter each tag bit to its permuted slot (inverse map, 3 = 7^-1 mod 20)
  function automatic logic [SW-1:0] m_enc(input logic [31:0] a);
    logic [19:0] q;
    logic [7:0] f0, f1, f2, f3;
    logic [SW-1:0] r;
    for (int i = 0; i < 20; i++) q[(i * 3) % 20] = a[12 + i];
    f0 = {q[1:0], a[11:6]};
    f1 = q[9:2];
    f2 = q[17:10];
    f3 = {q[5:0], q[19:18]};
    r = '0;
    r[f0] = 1'b1;
    r[256 + int'(f1)] = 1'b1;
    r[512 + int'(f2)] = 1'b1;
    r[768 + int'(f3)] = 1'b1;
    return r;
  endfunction

  function automatic bit m_empty(input logic [SW-1:0] s);
    for (int k = 0; k < 4; k++) if (s[k*256 +: 256] == '0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] m_mask(input logic [SW-1:0] s);
    logic [63:0] m;
    bit hole;
    hole = (s[256 +: 256] == '0) || (s[512 +: 256] == '0) || (s[768 +: 256] == '0);
    for (int i = 0; i < 64; i++)
      m[i] = hole | s[i] | s[64 + i] | s[128 + i] | s[192 + i];
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // queries are combinational; sample a nanosecond after setting selects
  task automatic query(input logic [1:0] a, input logic [1:0] b, input logic [31:0] ad,
                       input string req);
    src_a_sel = a; src_b_sel = b; addr = ad;
    #1;
    chk(sig_out === model[a], req, "sig_out popcount", 64'($countones(sig_out)),
        64'($countones(model[a])));
    chk(sig_empty === m_empty(model[a]), req, "sig_empty", 64'(sig_empty), 64'(m_empty(model[a])));
    chk(isect_empty === m_empty(model[a] & model[b]), req, "isect_empty",
        64'(isect_empty), 64'(m_empty(model[a] & model[b])));
    chk(addr_member === !m_empty(m_enc(ad) & model[a]), req, "addr_member",
        64'(addr_member), 64'(!m_empty(m_enc(ad) & model[a])));
  endtask

  task automatic do_op(input logic [2:0] op, input logic [1:0] d, input logic [1:0] a,
                       input logic [1:0] b, input logic [31:0] ad, input bit vld);
    logic [63:0] exp_mask;
    exp_mask = m_mask(model[a]);
    @(negedge clk);
    op_valid = vld; op_code = op; dst_sel = d; src_a_sel = a; src_b_sel = b; addr = ad;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    if (vld) begin
      case (op)
        3'd1: model[d] = '0;
        3'd2: model[d] = model[d] | m_enc(ad);
        3'd3: model[d] = model[a] & model[b];
        3'd4: model[d] = model[a] | model[b];
        default: ;
      endcase
    end
    // R9 strobe and mask
    chk(set_mask_valid === (vld && op == 3'd5), "R9", "set_mask_valid",
        64'(set_mask_valid), 64'(vld && op == 3'd5));
    if (vld && op == 3'd5) chk(set_mask === exp_mask, "R9", "set_mask", set_mask, exp_mask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [16];
    void'($urandom(32'd1234));
    for (int r = 0; r < 4; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(set_mask_valid === 1'b0, "R1", "set_mask_valid", 64'(set_mask_valid), 64'd0);
    for (int r = 0; r < 4; r++) begin
      query(2'(r), 2'(r), 32'h0, "R1");
    end

    // R2: single accumulate, member and encoding
    do_op(3'd2, 2'd0, 2'd0, 2'd0, 32'h0000_1000, 1'b1);
    query(2'd0, 2'd0, 32'h0000_1000, "R2");
    chk(addr_member === 1'b1, "R8", "self member", 64'(addr_member), 64'd1);

    // R6: partly filled signature (field 0 empty) still reads empty
    do_op(3'd2, 2'd1, 2'd0, 2'd0, 32'h0000_1040, 1'b1);
    do_op(3'd3, 2'd2, 2'd0, 2'd1, 32'h0, 1'b1);
    query(2'd2, 2'd2, 32'h0000_1000, "R6");
    chk(sig_out !== '0 && sig_empty === 1'b1, "R6", "one empty field", 64'(sig_empty), 64'd1);
    query(2'd0, 2'd1, 32'h0000_1040, "R7");
    chk(isect_empty === 1'b1, "R7", "set-only difference", 64'(isect_empty), 64'd1);

    // R5 / R9: union then decode
    do_op(3'd4, 2'd3, 2'd0, 2'd1, 32'h0, 1'b1);
    query(2'd3, 2'd0, 32'h0000_1040, "R5");
    do_op(3'd5, 2'd0, 2'd3, 2'd0, 32'h0, 1'b1);
    chk(set_mask === 64'h3, "R9", "sets 0 and 1", set_mask, 64'h3);
    do_op(3'd0, 2'd0, 2'd3, 2'd0, 32'h0, 1'b1);
    // decode of an empty register marks every set
    do_op(3'd1, 2'd2, 2'd0, 2'd0, 32'h0, 1'b1);
    do_op(3'd5, 2'd0, 2'd2, 2'd0, 32'h0, 1'b1);

    // R10: ignored operations leave the bank unchanged
    do_op(3'd1, 2'd0, 2'd0, 2'd0, 32'h0, 1'b0);
    query(2'd0, 2'd0, 32'h0000_1000, "R10");
    do_op(3'd6, 2'd1, 2'd0, 2'd0, 32'hFFFF_FFFF, 1'b1);
    query(2'd1, 2'd0, 32'h0000_1040, "R10");

    // R3: clear
    do_op(3'd1, 2'd3, 2'd0, 2'd0, 32'h0, 1'b1);
    query(2'd3, 2'd0, 32'h0, "R3");

    // R8: no false negatives over many accumulated addresses
    for (int i = 0; i < 16; i++) begin
      addrs[i] = $urandom();
      do_op(3'd2, 2'd3, 2'd0, 2'd0, addrs[i], 1'b1);
    end
    for (int i = 0; i < 16; i++) begin
      query(2'd3, 2'd0, addrs[i], "R8");
      chk(addr_member === 1'b1, "R8", "accumulated member", 64'(addr_member), 64'd1);
    end

    // random mix: R2 R3 R4 R5 R7 R9 R10
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      logic [31:0] ad;
      op = 3'($urandom_range(0, 5));
      if (op == 3'd1 && $urandom_range(0, 3) != 0) op = 3'd2;
      ad = $urandom();
      if ($urandom_range(0, 1) == 1) ad = addrs[$urandom_range(0, 15)];
      do_op(op, 2'($urandom()), 2'($urandom()), 2'($urandom()), ad,
            $urandom_range(0, 7) != 0);
      query(2'($urandom()), 2'($urandom()),
            ($urandom_range(0, 1) == 1) ? addrs[$urandom_range(0, 15)] : $urandom(),
            "R4");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule